// File: doc/BRIEF.md
# Start-Bit Framed Serial Segment Latch

This block takes display data over a two-wire serial link, one data line and the clock, plus an active-high enable. It drives a bank of static segment outputs. A frame opens with a single '1' start bit and carries one data bit per segment. A few pad clocks follow the data. No strobe pin moves the data to the outputs. The block counts the enabled clocks of the frame itself, and on the final one it copies the shifted word into the output latches and empties the shift chain. The outputs then hold that word until the next complete frame ends.

With the default parameters, a frame is 36 enabled clocks long: the start bit, 32 data bits and 3 pad clocks. The block runs on the serial clock and samples data and enable on its rising edge. A clock edge with the enable low has no effect, so a host may stall in the middle of a frame. A host may also send frames back to back, with no idle clock between them. Zeros sent while no frame is open are ignored, which lets the link idle low between frames.

Top module: `segment_serial_latch`

## Requirements
- R1: While no frame is open, an enabled clock edge with `sd_in` = 0 is ignored. An enabled edge with `sd_in` = 1 is the start bit and counts as edge 1 of a frame.
- R2: The data bit on enabled edge k+2 of a frame (k = 0..31) ends up on `seg_out[k]`. The first bit after the start bit drives `seg_out[0]`.
- R3: `seg_out` changes only on enabled edge 36 of a frame, and on that edge it takes the 32 data bits. After edge 35, `seg_out` still shows the previous word.
- R4: The data values on enabled edges 34, 35 and 36 (the pad clocks) are ignored. A '1' on any of them neither changes the loaded word nor opens a new frame.
- R5: Edge 36 empties the shift chain and closes the frame. The very next enabled edge with `sd_in` = 1 starts a new frame, so frames sent back to back each load correctly.
- R6: `load_done` is high for exactly the one clock cycle that follows edge 36, and is low at all other times.
- R7: A clock edge with `sd_en` = 0 changes nothing: the edge count, the shift chain and the outputs keep their values, and the data line is ignored. Counting resumes when the enable returns.
- R8: A frame that has fewer than 36 enabled edges never loads. `seg_out` holds its value until the missing edges arrive.
- R9: A synchronous reset (`rst` = 1 at a rising edge) clears `seg_out` and `load_done` to 0 and abandons any open frame.
- R10: Between loads, `seg_out` holds its value at every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sd_in | input | 1 | Serial data bit |
| sd_en | input | 1 | Active-high enable that qualifies each clock edge |
| seg_out | output | 32 | Latched segment outputs |
| load_done | output | 1 | One-cycle pulse after a frame has loaded |

## Verification
The assertions are checked on every cycle. They cover the following:
- A disabled edge leaves the edge count and the shift chain untouched.
- While idle, a zero never opens a frame.
- The shift chain is empty after every load.
- The segment outputs move only together with the load pulse.
- The pulse lasts a single cycle.

Some behaviour only the bench's scenarios can show. These are the mapping of serial bit positions onto output indices, loading on exactly the 36th enabled edge, and pad bits having no effect. The same holds for frames sent back to back, stalls in mid-frame, partial frames and a reset in the middle of a frame.

// File: rtl/segl_pkg.sv
`timescale 1ns/1ps
package segl_pkg;

    // Where the frame counter stands within a frame
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_PAD  = 2'd2
    } segl_phase_e;

    function automatic int segl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/segl_frame_ctr.sv
`timescale 1ns/1ps
module segl_frame_ctr
    import segl_pkg::*;
#(
    parameter int SEG_W    = 32,
    parameter int PAD_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic sdata_i,
    output logic shift_o,
    output logic load_o
);
    localparam int IDX_MAX = segl_max(SEG_W, PAD_CLKS);
    localparam int IDX_W   = $clog2(IDX_MAX + 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(SEG_W - 1);
    localparam logic [IDX_W-1:0] PAD_LAST  = IDX_W'(PAD_CLKS - 1);

    typedef struct packed {
        segl_phase_e      phase;
        logic [IDX_W-1:0] idx;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            case (st_q.phase)
                PH_IDLE: begin
                    if (sdata_i) begin
                        st_d.phase = PH_DATA;
                        st_d.idx   = '0;
                    end
                end
                PH_DATA: begin
                    if (st_q.idx == DATA_LAST) begin
                        st_d.phase = PH_PAD;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                PH_PAD: begin
                    if (st_q.idx == PAD_LAST) begin
                        st_d.phase = PH_IDLE;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.idx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{phase: PH_IDLE, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o = en_i && (st_q.phase == PH_DATA);
    assign load_o  = en_i && (st_q.phase == PH_PAD) && (st_q.idx == PAD_LAST);

    // R7: a disabled edge freezes the frame position
    a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(st_q));

    // R1: a zero while idle never opens a frame
    a_r1_idle_needs_start: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_IDLE && en_i && !sdata_i) |=> (st_q.phase == PH_IDLE));

    // R5: every load closes the frame
    a_r5_load_closes: assert property (@(posedge clk) disable iff (rst)
        load_o |=> (st_q.phase == PH_IDLE));

    // R3: the data index stays inside the word
    a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_DATA) |-> (st_q.idx <= DATA_LAST));

endmodule

// File: rtl/segl_shift_chain.sv
`timescale 1ns/1ps
module segl_shift_chain #(
    parameter int SEG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_i,
    input  logic             clr_i,
    input  logic             bit_i,
    output logic [SEG_W-1:0] chain_o
);
    typedef struct packed {
        logic [SEG_W-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.bits = '0;
        end else if (shift_i) begin
            // New bits enter at the top; the earliest bit ends at index 0
            st_d.bits = {bit_i, st_q.bits[SEG_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain_o = st_q.bits;

    // R5: the chain is empty after a load
    a_r5_chain_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (chain_o == '0));

    // R7: no shift and no clear leaves the chain alone
    a_r7_chain_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_i && !clr_i) |=> $stable(chain_o));

endmodule

// File: rtl/segl_out_latch.sv
`timescale 1ns/1ps
module segl_out_latch #(
    parameter int SEG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [SEG_W-1:0] word_i,
    output logic [SEG_W-1:0] seg_o,
    output logic             done_o
);
    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic             done;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = load_i;
        if (load_i) begin
            st_d.seg = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o  = st_q.seg;
    assign done_o = st_q.done;

    // R10: no load, no change
    a_r10_seg_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(seg_o));

endmodule

// File: rtl/segment_serial_latch.sv
`timescale 1ns/1ps
module segment_serial_latch #(
    parameter int SEG_W    = 32,
    parameter int PAD_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sd_in,
    input  logic             sd_en,
    output logic [SEG_W-1:0] seg_out,
    output logic             load_done
);
    logic             shift_w;
    logic             load_w;
    logic [SEG_W-1:0] chain_w;

    segl_frame_ctr #(
        .SEG_W    (SEG_W),
        .PAD_CLKS (PAD_CLKS)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .en_i    (sd_en),
        .sdata_i (sd_in),
        .shift_o (shift_w),
        .load_o  (load_w)
    );

    segl_shift_chain #(
        .SEG_W (SEG_W)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift_w),
        .clr_i   (load_w),
        .bit_i   (sd_in),
        .chain_o (chain_w)
    );

    segl_out_latch #(
        .SEG_W (SEG_W)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_w),
        .word_i (chain_w),
        .seg_o  (seg_out),
        .done_o (load_done)
    );

    // R6: the load pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        load_done |=> !load_done);

    // R3: outputs move only together with the load pulse
    a_r3_seg_moves_on_load: assert property (@(posedge clk) disable iff (rst)
        (seg_out != $past(seg_out)) |-> load_done);

    // R9: reset leaves outputs cleared
    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (seg_out == '0 && !load_done));

endmodule

// File: tb/segment_serial_latch_bench.sv
`timescale 1ns/1ps
module segment_serial_latch_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sd_in = 1'b0;
    logic        sd_en = 1'b0;
    logic [31:0] seg_out;
    logic        load_done;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    segment_serial_latch u_segment_serial_latch (
        .clk       (clk),
        .rst       (rst),
        .sd_in     (sd_in),
        .sd_en     (sd_en),
        .seg_out   (seg_out),
        .load_done (load_done)
    );

    // bit 32 = value driven on the pad clocks, bits 31:0 = data word
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 32'h0000_0001},
        {1'b1, 32'h8000_0000},
        {1'b1, 32'hA5A5_5A5A},
        {1'b0, 32'hFFFF_FFFF},
        {1'b1, 32'h0000_0000},
        {1'b1, 32'h1234_5678}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic edge_bit(input logic d, input logic e);
        sd_in = d;
        sd_en = e;
        @(negedge clk);
    endtask

    task automatic send_edges(input logic [31:0] w, input int first, input int last, input logic padv);
        for (int n = first; n <= last; n++) begin
            if (n == 1)       edge_bit(1'b1, 1'b1);
            else if (n <= 33) edge_bit(w[n-2], 1'b1);
            else              edge_bit(padv, 1'b1);
        end
        sd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        sd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] prev;
        logic [31:0] w;
        logic        p;

        @(negedge clk);
        do_reset();
        chk(seg_out, 32'h0, "R9 reset seg");
        chk({31'h0, load_done}, 32'h0, "R9 reset load_done");

        // R1: leading zeros while idle are ignored
        repeat (5) edge_bit(1'b0, 1'b1);
        sd_en = 1'b0;
        chk({31'h0, load_done}, 32'h0, "R1 idle zeros no load");
        send_edges(32'hDEAD_BEEF, 1, 36, 1'b0);
        chk(seg_out, 32'hDEAD_BEEF, "R1 frame after idle zeros");
        prev = 32'hDEAD_BEEF;

        // Table: back-to-back frames
        for (int v = 0; v < 6; v++) begin
            w = VEC[v][31:0];
            p = VEC[v][32];
            send_edges(w, 1, 1, p);
            chk({31'h0, load_done}, 32'h0, "R6 pulse gone next cycle");
            chk(seg_out, prev, "R10 hold at frame start");
            send_edges(w, 2, 35, p);
            chk(seg_out, prev, "R3 no load by edge 35");
            chk({31'h0, load_done}, 32'h0, "R3 no pulse by edge 35");
            send_edges(w, 36, 36, p);
            chk(seg_out, w, "R2 R4 R5 loaded word");
            chk({31'h0, load_done}, 32'h1, "R6 pulse after edge 36");
            prev = w;
        end

        // R7: disabled edges carrying inverted data in between
        w = 32'h0F0F_1234;
        for (int n = 1; n <= 36; n++) begin
            logic d;
            d = (n == 1) ? 1'b1 : (n <= 33) ? w[n-2] : 1'b0;
            edge_bit(d, 1'b1);
            if (n < 36) begin
                edge_bit(~d, 1'b0);
                edge_bit(1'b1, 1'b0);
            end
        end
        sd_en = 1'b0;
        chk(seg_out, w, "R7 stalled frame word");
        chk({31'h0, load_done}, 32'h1, "R7 stalled frame pulse");
        prev = w;

        // R8: partial frame waits
        w = 32'h55AA_33CC;
        send_edges(w, 1, 20, 1'b0);
        repeat (12) edge_bit(1'b1, 1'b0);
        chk(seg_out, prev, "R8 partial frame holds");
        chk({31'h0, load_done}, 32'h0, "R8 partial frame no pulse");
        send_edges(w, 21, 36, 1'b0);
        chk(seg_out, w, "R8 completed frame");

        // R9: reset abandons a half frame
        send_edges(32'hFFFF_0000, 1, 10, 1'b0);
        do_reset();
        chk(seg_out, 32'h0, "R9 reset mid frame seg");
        w = 32'h8765_4321;
        send_edges(w, 1, 35, 1'b1);
        chk({31'h0, load_done}, 32'h0, "R9 fresh count after reset");
        chk(seg_out, 32'h0, "R9 no early load");
        send_edges(w, 36, 36, 1'b1);
        chk(seg_out, w, "R9 frame after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule